// File: doc/BRIEF.md
# UART Interrupt Identification and Prioritizer

This block gathers the interrupt sources of a FIFO-based UART and turns them into one identification code for software to read. A line-error event, the receive FIFO fill level measured against a selectable trigger point, a character-timeout event and the transmit FIFO empty flag are the sources. The block ranks them in three priority levels and reports only the most urgent enabled one.

The block also owns the transmit-empty pending latch. That latch is held off for a programmable number of clocks after reset and after each write to the transmit holding register. The hold-off stands for one character time less the stop bit, so software can refill the FIFO before the interrupt appears. Reading the identification register drops the transmit-empty condition, but only while that condition is the one being shown.

The line-error latch and the timeout latch also live here. The serial shifters, the FIFOs and the baud timer are outside the block and drive its inputs.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, `id_code` is 4'b0001, `int_n` is 1 and `irq` is 0.
- R2: A pulse on `rx_err_evt` latches a line error, and on the next cycle the code is 4'b0110, above every other source. A `lsr_rd` pulse clears it, unless a new `rx_err_evt` arrives in the same cycle, in which case it stays pending.
- R3: While `rx_level` is at or above the trigger level, the code is 4'b0100, provided no line error is pending. The trigger level comes from `trig_sel`: 2'b00 gives 1, 2'b01 gives FIFO_DEPTH/4, 2'b10 gives FIFO_DEPTH/2 and 2'b11 gives FIFO_DEPTH-2. With the default depth of 16, these are 1, 4, 8 and 14.
- R4: As soon as `rx_level` drops below the trigger level, the receive-data source is no longer reported. There is no delay.
- R5: A pulse on `tmo_evt` latches a timeout, reported as 4'b1100. An `rx_rd` or `rx_wr` pulse clears it. If FIFO activity arrives in the same cycle as the event, the activity wins and nothing is latched.
- R6: When receive-data and timeout are both active, the code is 4'b0100.
- R7: Transmit-empty has the lowest priority and is reported as 4'b0010. It becomes pending when `tx_empty` is high and the hold-off has run out, and it is raised only on the rising edge of that combined condition.
- R8: A `thr_wr` pulse clears a pending transmit-empty on the next cycle and restarts the hold-off.
- R9: An `iir_rd` pulse clears transmit-empty only if `id_code` reads 4'b0010 in that cycle. A read while any other code is shown leaves it pending.
- R10: For HOLDOFF_CYC clocks after reset, or after a `thr_wr`, transmit-empty cannot become pending.
- R11: `ien` bit 0 enables line error, bit 1 receive-data, bit 2 timeout and bit 3 transmit-empty. A disabled source is left out of the ranking. `int_n` is `id_code[0]`, `irq` is its inverse, and only the five listed codes ever appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ien | input | 4 | Per-source enables (line, rx data, timeout, tx empty) |
| rx_err_evt | input | 1 | Line error event pulse |
| lsr_rd | input | 1 | Line status register read strobe |
| rx_level | input | $clog2(FIFO_DEPTH+1) | Receive FIFO fill count |
| trig_sel | input | 2 | Trigger level select |
| tmo_evt | input | 1 | Character timeout event pulse |
| rx_rd | input | 1 | Receive FIFO read strobe |
| rx_wr | input | 1 | Receive FIFO write strobe |
| tx_empty | input | 1 | Transmit FIFO empty flag |
| thr_wr | input | 1 | Transmit holding register write strobe |
| iir_rd | input | 1 | Identification register read strobe |
| id_code | output | 4 | Prioritized identification code |
| int_n | output | 1 | Low while an interrupt is pending |
| irq | output | 1 | Combined interrupt request |

## Verification
The delicate same-cycle overlap is an identification read that arrives in the very cycle a higher-priority source appears while transmit-empty is latched. The bench raises the receive level to the trigger and pulses `iir_rd` together with it. It then confirms that the code read was 4'b0100 and that 4'b0010 comes back once the level drops. A second overlap puts a timeout event in the same cycle as receive FIFO activity and expects nothing to be latched. A third puts a line-status read in the same cycle as a new error and expects the error to stay.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

   typedef enum logic [3:0] {
      ID_NONE    = 4'b0001,
      ID_LINE    = 4'b0110,
      ID_RXDATA  = 4'b0100,
      ID_TMO     = 4'b1100,
      ID_TXEMPTY = 4'b0010
   } irq_id_e;

   // trigger level in characters for a select value and FIFO depth
   function automatic int unsigned trig_chars(input logic [1:0] sel, input int unsigned depth);
      case (sel)
         2'b00:   return 1;
         2'b01:   return depth / 4;
         2'b10:   return depth / 2;
         default: return depth - 2;
      endcase
   endfunction

endpackage

// File: rtl/uart_irq_trig.sv
module uart_irq_trig #(
   parameter int unsigned FIFO_DEPTH = 16,
   localparam int unsigned LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
   input  logic [LVL_W-1:0] rx_level,
   input  logic [1:0]       trig_sel,
   output logic             hit
);
   import uart_irq_pkg::*;

   logic [LVL_W-1:0] thresh;

   generate
      if (FIFO_DEPTH == 16) begin : g_fixed16
         always_comb begin
            case (trig_sel)
               2'b00:   thresh = LVL_W'(1);
               2'b01:   thresh = LVL_W'(4);
               2'b10:   thresh = LVL_W'(8);
               default: thresh = LVL_W'(14);
            endcase
         end
      end else begin : g_computed
         localparam logic [LVL_W-1:0] T0 = LVL_W'(trig_chars(2'b00, FIFO_DEPTH));
         localparam logic [LVL_W-1:0] T1 = LVL_W'(trig_chars(2'b01, FIFO_DEPTH));
         localparam logic [LVL_W-1:0] T2 = LVL_W'(trig_chars(2'b10, FIFO_DEPTH));
         localparam logic [LVL_W-1:0] T3 = LVL_W'(trig_chars(2'b11, FIFO_DEPTH));
         always_comb begin
            case (trig_sel)
               2'b00:   thresh = T0;
               2'b01:   thresh = T1;
               2'b10:   thresh = T2;
               default: thresh = T3;
            endcase
         end
      end
   endgenerate

   assign hit = (rx_level >= thresh);

endmodule

// File: rtl/uart_irq_txe.sv
module uart_irq_txe #(
   parameter int unsigned HOLDOFF_CYC = 40,
   localparam int unsigned CW         = $clog2(HOLDOFF_CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_empty,
   input  logic thr_wr,
   input  logic iir_clr,
   output logic pend
);
   localparam logic [CW-1:0] RELOAD = CW'(HOLDOFF_CYC);

   logic [CW-1:0] hold_cnt;
   logic          qual, qual_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              hold_cnt <= RELOAD;
      else if (thr_wr)         hold_cnt <= RELOAD;
      else if (hold_cnt != '0) hold_cnt <= hold_cnt - CW'(1);
   end

   assign qual = tx_empty && (hold_cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         qual_q <= 1'b0;
         pend   <= 1'b0;
      end else begin
         qual_q <= qual;
         if (thr_wr)              pend <= 1'b0;
         else if (qual && !qual_q) pend <= 1'b1;
         else if (iir_clr)        pend <= 1'b0;
      end
   end

   AST_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      thr_wr |=> !pend); // R8
   AST_HOLDOFF_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend) |-> ($past(hold_cnt) == '0 && $past(tx_empty))); // R10

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
   import uart_irq_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    src_line,
   input  logic    src_rxdata,
   input  logic    src_tmo,
   input  logic    src_txe,
   output irq_id_e id
);
   always_comb begin
      if (src_line)        id = ID_LINE;
      else if (src_rxdata) id = ID_RXDATA;
      else if (src_tmo)    id = ID_TMO;
      else if (src_txe)    id = ID_TXEMPTY;
      else                 id = ID_NONE;
   end

   AST_RXDATA_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (src_rxdata && src_tmo && !src_line) |-> id == ID_RXDATA); // R6
   AST_LINE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      src_line |-> id == ID_LINE); // R2

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
   import uart_irq_pkg::*;
#(
   parameter int unsigned FIFO_DEPTH  = 16,
   parameter int unsigned HOLDOFF_CYC = 40,
   localparam int unsigned LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       ien,
   input  logic             rx_err_evt,
   input  logic             lsr_rd,
   input  logic [LVL_W-1:0] rx_level,
   input  logic [1:0]       trig_sel,
   input  logic             tmo_evt,
   input  logic             rx_rd,
   input  logic             rx_wr,
   input  logic             tx_empty,
   input  logic             thr_wr,
   input  logic             iir_rd,
   output logic [3:0]       id_code,
   output logic             int_n,
   output logic             irq
);
   generate
      if (FIFO_DEPTH < 8 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("FIFO_DEPTH must be a power of two of at least 8");
      end
      if (HOLDOFF_CYC < 1) begin : g_bad_holdoff
         $error("HOLDOFF_CYC must be at least 1");
      end
   endgenerate

   logic    line_pend, tmo_pend, rda_hit, txe_pend, txe_clr;
   irq_id_e id;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          line_pend <= 1'b0;
      else if (rx_err_evt) line_pend <= 1'b1;
      else if (lsr_rd)     line_pend <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              tmo_pend <= 1'b0;
      else if (rx_rd || rx_wr) tmo_pend <= 1'b0;
      else if (tmo_evt)        tmo_pend <= 1'b1;
   end

   uart_irq_trig #(.FIFO_DEPTH(FIFO_DEPTH)) u_trig (
      .rx_level (rx_level),
      .trig_sel (trig_sel),
      .hit      (rda_hit)
   );

   assign txe_clr = iir_rd && (id == ID_TXEMPTY);

   uart_irq_txe #(.HOLDOFF_CYC(HOLDOFF_CYC)) u_txe (
      .clk      (clk),
      .rst_n    (rst_n),
      .tx_empty (tx_empty),
      .thr_wr   (thr_wr),
      .iir_clr  (txe_clr),
      .pend     (txe_pend)
   );

   uart_irq_prio u_prio (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_line   (line_pend & ien[0]),
      .src_rxdata (rda_hit   & ien[1]),
      .src_tmo    (tmo_pend  & ien[2]),
      .src_txe    (txe_pend  & ien[3]),
      .id         (id)
   );

   assign id_code = id;
   assign int_n   = id[0];
   assign irq     = ~id[0];

   AST_LSR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (lsr_rd && !rx_err_evt) |=> !line_pend); // R2
   AST_ACT_CLEARS_TMO: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_rd || rx_wr) |=> !tmo_pend); // R5
   AST_READ_KEEPS_TXE: assert property (@(posedge clk) disable iff (!rst_n)
      (iir_rd && txe_pend && id != ID_TXEMPTY && !thr_wr) |=> txe_pend); // R9
   AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> |({txe_pend, tmo_pend, rda_hit, line_pend} & ien)); // R11
   AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      id_code inside {4'b0001, 4'b0110, 4'b0100, 4'b1100, 4'b0010}); // R11

endmodule

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;
   localparam int unsigned DEPTH = 16;
   localparam int unsigned H     = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] ien = 4'hF;
   logic       rx_err_evt = 0, lsr_rd = 0, tmo_evt = 0, rx_rd = 0, rx_wr = 0;
   logic       tx_empty = 1, thr_wr = 0, iir_rd = 0;
   logic [4:0] rx_level = '0;
   logic [1:0] trig_sel = '0;
   logic [3:0] id_code;
   logic       int_n, irq;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #5 clk = ~clk;

   uart_irq_ident #(.FIFO_DEPTH(DEPTH), .HOLDOFF_CYC(H)) u_uart_irq_ident (
      .clk(clk), .rst_n(rst_n), .ien(ien), .rx_err_evt(rx_err_evt), .lsr_rd(lsr_rd),
      .rx_level(rx_level), .trig_sel(trig_sel), .tmo_evt(tmo_evt), .rx_rd(rx_rd),
      .rx_wr(rx_wr), .tx_empty(tx_empty), .thr_wr(thr_wr), .iir_rd(iir_rd),
      .id_code(id_code), .int_n(int_n), .irq(irq)
   );

   task automatic step(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic chk(input logic [3:0] exp, input string req);
      #1;
      n_chk++;
      if (id_code !== exp || int_n !== exp[0] || irq !== ~exp[0]) begin
         n_fail++;
         $display("FAIL %s: id=%b int_n=%b irq=%b expected id=%b int_n=%b irq=%b",
                  req, id_code, int_n, irq, exp, exp[0], ~exp[0]);
      end
   endtask

   task automatic t_reset_holdoff;
      chk(4'b0001, "R1 reset state");
      @(negedge clk); rst_n = 1'b1;
      step(H - 1);
      chk(4'b0001, "R10 holdoff after reset");
      step(4);
      chk(4'b0010, "R7 tx empty after holdoff");
   endtask

   task automatic t_iir_clear;
      iir_rd = 1; step(); iir_rd = 0;
      chk(4'b0001, "R9 iir read clears tx empty");
      step(H + 3);
      chk(4'b0001, "R7 no re-raise without new edge");
   endtask

   task automatic t_thr_wr;
      tx_empty = 0; thr_wr = 1; step(); thr_wr = 0;
      step(2); tx_empty = 1;
      step(H - 3);
      chk(4'b0001, "R10 holdoff after write");
      step(H + 3);
      chk(4'b0010, "R7 tx empty after write holdoff");
      thr_wr = 1; step(); thr_wr = 0;
      chk(4'b0001, "R8 write clears tx empty");
      step(H + 3);
      chk(4'b0010, "R8 holdoff restarted then re-raised");
   endtask

   task automatic t_trigger;
      int lv [4] = '{1, 4, 8, 14};
      for (int s = 0; s < 4; s++) begin
         trig_sel = 2'(s);
         rx_level = 5'(lv[s] - 1);
         chk(4'b0010, "R4 below trigger");
         rx_level = 5'(lv[s]);
         chk(4'b0100, "R3 at trigger");
         rx_level = 5'(lv[s] + 1);
         chk(4'b0100, "R3 above trigger");
         rx_level = 5'(lv[s] - 1);
         chk(4'b0010, "R4 falls below trigger");
      end
      rx_level = '0;
   endtask

   task automatic t_iir_hidden;
      trig_sel = 2'b11; rx_level = 5'd14; iir_rd = 1;
      chk(4'b0100, "R9 higher source shown during read");
      step(); iir_rd = 0; rx_level = '0;
      chk(4'b0010, "R9 tx empty kept after read of other code");
   endtask

   task automatic t_timeout;
      tmo_evt = 1; step(); tmo_evt = 0;
      chk(4'b1100, "R5 timeout reported");
      trig_sel = 2'b10; rx_level = 5'd8;
      chk(4'b0100, "R6 rx data ahead of timeout");
      rx_level = '0;
      chk(4'b1100, "R5 timeout still pending");
      rx_rd = 1; step(); rx_rd = 0;
      chk(4'b0010, "R5 read clears timeout");
      tmo_evt = 1; rx_wr = 1; step(); tmo_evt = 0; rx_wr = 0;
      chk(4'b0010, "R5 activity wins over event");
      tmo_evt = 1; step(); tmo_evt = 0;
      rx_wr = 1; step(); rx_wr = 0;
      chk(4'b0010, "R5 write clears timeout");
   endtask

   task automatic t_line;
      rx_err_evt = 1; step(); rx_err_evt = 0;
      chk(4'b0110, "R2 line error reported");
      trig_sel = 2'b00; rx_level = 5'd3; tmo_evt = 1; step(); tmo_evt = 0;
      chk(4'b0110, "R2 line error above all");
      lsr_rd = 1; rx_err_evt = 1; step(); lsr_rd = 0; rx_err_evt = 0;
      chk(4'b0110, "R2 new error during read stays");
      lsr_rd = 1; step(); lsr_rd = 0;
      chk(4'b0100, "R2 lsr read clears error");
      rx_level = '0; rx_rd = 1; step(); rx_rd = 0;
      chk(4'b0010, "R2 back to tx empty");
   endtask

   task automatic t_mask;
      ien = 4'b0111;
      chk(4'b0001, "R11 tx empty masked");
      iir_rd = 1; step(); iir_rd = 0;
      ien = 4'hF;
      chk(4'b0010, "R11 masked read leaves tx empty");
      ien = 4'b1101; rx_level = 5'd5;
      chk(4'b0010, "R11 rx data masked");
      ien = 4'b1111;
      chk(4'b0100, "R11 rx data enabled");
      rx_level = '0;
   endtask

   initial begin
      step(2);
      t_reset_holdoff();
      t_iir_clear();
      t_thr_wr();
      t_trigger();
      t_iir_hidden();
      t_timeout();
      t_line();
      t_mask();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: run did not end, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule